// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block collects 64 level-sensitive interrupt lines and presents them to a processor as two request outputs. The first is an ordinary request and the second is a fast request. Software sets up the block through a 32-bit register bus that uses word addresses. It can turn single sources on or off by writing a source number, or it can write whole enable words. It chooses which output each source drives, gives each ordinary source a 4-bit priority, and sets a global threshold that a priority must exceed before the ordinary output fires.

Two vector words show the winning source and its priority. They are computed by hardware, so a handler can read the ordinary vector word again and again, servicing each source it reports, until the word shows the idle code. A pending bit always follows its live input: it is the input ORed with the source's software-force bit, and the result is gated by the source's enable bit. Software can also read back the raw inputs, the force bits, and the pending bits for each output.

Top module: `irq_vector_ctrl`

Register words, listed by bus word index (byte offset / 4):
| Word | Access | Content |
|---|---|---|
| 0 | rw | control word (storage only) |
| 1 | rw | priority threshold, bits 4:0 |
| 2 / 3 | w | set / clear the enable bit of source N |
| 4 / 5 | rw | enable, sources 32-63 / 0-31 |
| 6 / 7 | rw | output select, sources 32-63 / 0-31 |
| 8..15 | rw | priority words 7..0 |
| 16 / 17 | r | ordinary / fast vector |
| 18 / 19 | r | raw inputs, high / low |
| 20 / 21 | rw | force bits, high / low |
| 22 / 23 | r | ordinary pending, high / low |
| 24 / 25 | r | fast pending, high / low |

## Requirements
- R1: After reset the following values hold: control word 0, threshold 0x1F, all enable bits 0, all select bits 0, all priorities 0. Both vector words read 0xFFFF0000 and both outputs are low.
- R2: Writing N to word 2 sets enable bit N and writing N to word 3 clears it. A written value of 64 or more changes no enable bit.
- R3: Pending for source i is (input i OR force i) AND enable i. Select bit 1 places it in the fast pending view and select bit 0 places it in the ordinary view. Words 18/19 show the live inputs.
- R4: Priority word x sits at word index 15-x and holds sources 8x to 8x+7. Source 8x+k takes bits 4k+3:4k.
- R5: The ordinary vector reads {source number, 12'b0, priority}. It reports the ordinary pending source of highest priority among those whose priority is strictly greater than the threshold, and on a tie the higher source number wins. When no such source exists it reads 0xFFFF0000.
- R6: A threshold of 15 or more blocks every ordinary source, so the vector is idle and the ordinary output stays low.
- R7: The fast vector reads {highest-numbered fast pending source, 16'b0}, or 0xFFFF0000 when there is none.
- R8: Each output rises on the first clock edge after a qualifying pending bit appears and falls on the first edge after it goes away.
- R9: Words 4-7 and 20-21 read back what was written, with the high word covering sources 32-63. Read data appears one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bus_sel | input | 1 | bus access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 5 | register word index |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, one cycle after address |
| irq_src | input | 64 | level-sensitive interrupt inputs |
| irq_norm_o | output | 1 | ordinary interrupt request |
| irq_fast_o | output | 1 | fast interrupt request |

## Verification
The arbitration is driven with these input sets:
- all inputs quiet;
- a single source;
- every source at once, which separates the maximum-priority winner from the highest-numbered one;
- two sources of equal priority, which exposes the tie-break direction;
- thresholds of 3, 14, 15 and 0x1F, which show whether the compare is strict and whether the threshold blocks everything;
- mixed output-select patterns, which show whether fast sources leak into the ordinary vector or ordinary sources into the fast one.

Directed cases then cover numbered enable writes, including out-of-range values, force bits without a live input, priority field placement at both ends of the priority words, and the one-cycle latency of the outputs.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int SRC_N = 64;
  localparam int PRI_W = 4;
  localparam int MSK_W = 5;
  localparam logic [15:0] IDLE_CODE = 16'hFFFF;

  // register word indices
  localparam logic [4:0] W_CTRL  = 5'd0;
  localparam logic [4:0] W_MASK  = 5'd1;
  localparam logic [4:0] W_ENNUM = 5'd2;
  localparam logic [4:0] W_DSNUM = 5'd3;
  localparam logic [4:0] W_ENH   = 5'd4;
  localparam logic [4:0] W_ENL   = 5'd5;
  localparam logic [4:0] W_TYH   = 5'd6;
  localparam logic [4:0] W_TYL   = 5'd7;
  localparam logic [4:0] W_NVEC  = 5'd16;
  localparam logic [4:0] W_FVEC  = 5'd17;
  localparam logic [4:0] W_RAWH  = 5'd18;
  localparam logic [4:0] W_RAWL  = 5'd19;
  localparam logic [4:0] W_FRCH  = 5'd20;
  localparam logic [4:0] W_FRCL  = 5'd21;
  localparam logic [4:0] W_NPH   = 5'd22;
  localparam logic [4:0] W_NPL   = 5'd23;
  localparam logic [4:0] W_FPH   = 5'd24;
  localparam logic [4:0] W_FPL   = 5'd25;

  // a priority qualifies only when strictly above the threshold
  function automatic logic pri_passes(input logic [PRI_W-1:0] p,
                                      input logic [MSK_W-1:0] m);
    return MSK_W'(p) > m;
  endfunction

  // vector word: number in the upper half, priority in the lower half
  function automatic logic [31:0] vec_word(input logic hit,
                                           input logic [15:0] num,
                                           input logic [15:0] pri);
    return hit ? {num, pri} : {IDLE_CODE, 16'h0000};
  endfunction

  // a numbered enable write is honoured only for a valid source number
  function automatic logic num_valid(input logic [31:0] v);
    return v < 32'(SRC_N);
  endfunction
endpackage

// File: rtl/vic_arbiter.sv
module vic_arbiter
  import vic_pkg::*;
#(
  parameter int N       = SRC_N,
  parameter int PW      = PRI_W,
  parameter int MW      = MSK_W,
  parameter bit BY_PRIO = 1'b1
) (
  input  logic [N-1:0]         req,
  input  logic [N*PW-1:0]      prio,
  input  logic [MW-1:0]        thresh,
  output logic                 found,
  output logic [$clog2(N)-1:0] win,
  output logic [PW-1:0]        win_pri
);
  localparam int IW = $clog2(N);

  logic [N-1:0]  ok;
  logic [PW-1:0] key [N];

  // with all keys equal the ascending scan leaves the highest number
  for (genvar g = 0; g < N; g++) begin : g_key
    assign key[g] = BY_PRIO ? prio[g*PW +: PW] : '0;
    assign ok[g]  = req[g] && (!BY_PRIO || pri_passes(prio[g*PW +: PW], thresh));
  end

  always_comb begin
    found   = 1'b0;
    win     = '0;
    win_pri = '0;
    for (int i = 0; i < N; i++) begin
      if (ok[i] && (!found || key[i] >= win_pri)) begin
        found   = 1'b1;
        win     = IW'(i);
        win_pri = key[i];
      end
    end
  end
endmodule

// File: rtl/vic_regfile.sv
module vic_regfile
  import vic_pkg::*;
#(
  parameter int N  = SRC_N,
  parameter int PW = PRI_W,
  parameter int MW = MSK_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel,
  input  logic            wr,
  input  logic [4:0]      widx,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  input  logic [N-1:0]    raw_src,
  input  logic [N-1:0]    norm_pend,
  input  logic [N-1:0]    fast_pend,
  input  logic [31:0]     norm_vec,
  input  logic [31:0]     fast_vec,
  output logic [N-1:0]    en_q,
  output logic [N-1:0]    type_q,
  output logic [N-1:0]    frc_q,
  output logic [N*PW-1:0] prio_flat,
  output logic [MW-1:0]   mask_q
);
  localparam int HALF = N / 2;
  localparam int IW   = $clog2(N);
  localparam int NPR  = (N * PW) / 32;

  logic [31:0] ctrl_q;
  logic [31:0] prio_reg [NPR];
  logic [31:0] rd_mux;

  // named bus events
  wire wr_ev      = sel && wr;
  wire num_ok     = num_valid(wdata);
  wire ennum_hit  = wr_ev && (widx == W_ENNUM) && num_ok;
  wire disnum_hit = wr_ev && (widx == W_DSNUM) && num_ok;
  wire badnum_hit = wr_ev && ((widx == W_ENNUM) || (widx == W_DSNUM)) && !num_ok;
  wire prio_hit   = (widx[4:3] == 2'b01);

  for (genvar x = 0; x < NPR; x++) begin : g_pflat
    assign prio_flat[x*32 +: 32] = prio_reg[x];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '1;
      en_q   <= '0;
      type_q <= '0;
      frc_q  <= '0;
      for (int x = 0; x < NPR; x++) prio_reg[x] <= '0;
    end else if (wr_ev) begin
      case (widx)
        W_CTRL:  ctrl_q <= wdata;
        W_MASK:  mask_q <= wdata[MW-1:0];
        W_ENNUM: if (num_ok) en_q[wdata[IW-1:0]] <= 1'b1;
        W_DSNUM: if (num_ok) en_q[wdata[IW-1:0]] <= 1'b0;
        W_ENH:   en_q[N-1:HALF]   <= wdata;
        W_ENL:   en_q[HALF-1:0]   <= wdata;
        W_TYH:   type_q[N-1:HALF] <= wdata;
        W_TYL:   type_q[HALF-1:0] <= wdata;
        W_FRCH:  frc_q[N-1:HALF]  <= wdata;
        W_FRCL:  frc_q[HALF-1:0]  <= wdata;
        default: if (prio_hit) prio_reg[~widx[2:0]] <= wdata;
      endcase
    end
  end

  always_comb begin
    case (widx)
      W_CTRL:  rd_mux = ctrl_q;
      W_MASK:  rd_mux = 32'(mask_q);
      W_ENH:   rd_mux = en_q[N-1:HALF];
      W_ENL:   rd_mux = en_q[HALF-1:0];
      W_TYH:   rd_mux = type_q[N-1:HALF];
      W_TYL:   rd_mux = type_q[HALF-1:0];
      W_NVEC:  rd_mux = norm_vec;
      W_FVEC:  rd_mux = fast_vec;
      W_RAWH:  rd_mux = raw_src[N-1:HALF];
      W_RAWL:  rd_mux = raw_src[HALF-1:0];
      W_FRCH:  rd_mux = frc_q[N-1:HALF];
      W_FRCL:  rd_mux = frc_q[HALF-1:0];
      W_NPH:   rd_mux = norm_pend[N-1:HALF];
      W_NPL:   rd_mux = norm_pend[HALF-1:0];
      W_FPH:   rd_mux = fast_pend[N-1:HALF];
      W_FPL:   rd_mux = fast_pend[HALF-1:0];
      default: rd_mux = prio_hit ? prio_reg[~widx[2:0]] : 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rdata <= '0;
    else if (sel && !wr) rdata <= rd_mux;
  end

  // R2
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ennum_hit |=> en_q[$past(wdata[IW-1:0])]);
  // R2
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disnum_hit |=> !en_q[$past(wdata[IW-1:0])]);
  // R2
  num_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    badnum_hit |=> $stable(en_q));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import vic_pkg::*;
#(
  parameter int N_SRC  = SRC_N,
  parameter int PRIO_W = PRI_W,
  parameter int MASK_W = MSK_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [4:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [N_SRC-1:0] irq_src,
  output logic             irq_norm_o,
  output logic             irq_fast_o
);
  localparam int IW = $clog2(N_SRC);

  logic [N_SRC-1:0]        en_q, type_q, frc_q;
  logic [N_SRC*PRIO_W-1:0] prio_flat;
  logic [MASK_W-1:0]       mask_q;
  logic [N_SRC-1:0]        pend, norm_pend, fast_pend;
  logic                    n_found, f_found;
  logic [IW-1:0]           n_win, f_win;
  logic [PRIO_W-1:0]       n_pri, f_pri;
  logic [31:0]             norm_vec, fast_vec;

  // level-sensitive pending, split by output select
  assign pend      = (irq_src | frc_q) & en_q;
  assign norm_pend = pend & ~type_q;
  assign fast_pend = pend & type_q;

  vic_regfile #(.N(N_SRC), .PW(PRIO_W), .MW(MASK_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (bus_sel),
    .wr        (bus_wr),
    .widx      (bus_addr),
    .wdata     (bus_wdata),
    .rdata     (bus_rdata),
    .raw_src   (irq_src),
    .norm_pend (norm_pend),
    .fast_pend (fast_pend),
    .norm_vec  (norm_vec),
    .fast_vec  (fast_vec),
    .en_q      (en_q),
    .type_q    (type_q),
    .frc_q     (frc_q),
    .prio_flat (prio_flat),
    .mask_q    (mask_q)
  );

  vic_arbiter #(.N(N_SRC), .PW(PRIO_W), .MW(MASK_W), .BY_PRIO(1'b1)) u_norm_arb (
    .req     (norm_pend),
    .prio    (prio_flat),
    .thresh  (mask_q),
    .found   (n_found),
    .win     (n_win),
    .win_pri (n_pri)
  );

  vic_arbiter #(.N(N_SRC), .PW(PRIO_W), .MW(MASK_W), .BY_PRIO(1'b0)) u_fast_arb (
    .req     (fast_pend),
    .prio    (prio_flat),
    .thresh  (mask_q),
    .found   (f_found),
    .win     (f_win),
    .win_pri (f_pri)
  );

  assign norm_vec = vec_word(n_found, 16'(n_win), 16'(n_pri));
  assign fast_vec = vec_word(f_found, 16'(f_win), 16'(f_pri));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_norm_o <= 1'b0;
      irq_fast_o <= 1'b0;
    end else begin
      irq_norm_o <= n_found;
      irq_fast_o <= f_found;
    end
  end

  // R5
  norm_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    n_found |-> (norm_pend[n_win] && pri_passes(prio_flat[n_win*PRIO_W +: PRIO_W], mask_q)));
  // R6
  mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(mask_q) >= 32'd15) |-> !n_found);
  // R7
  fast_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    f_found |-> (fast_pend[f_win] && !type_q[f_win] == 1'b0));
  // R8
  norm_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_pend == '0) |=> !irq_norm_o);
  // R8
  fast_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_pend != '0) |=> irq_fast_o);
endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [63:0] src = '0;
  wire  [31:0] rdata;
  wire         irq_n, irq_f;
  int          nchk = 0, nbad = 0;
  logic [31:0] d;

  always #4 clk = ~clk;

  irq_vector_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_src(src),
    .irq_norm_o(irq_n), .irq_fast_o(irq_f)
  );

  typedef struct packed {
    logic [63:0] s;
    logic [63:0] t;
    logic [4:0]  m;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{64'h0, 64'h0, 5'd0},
    '{64'h20, 64'h0, 5'd0},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 5'd0},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 5'd14},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 5'd15},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_0000_0000, 5'd0},
    '{64'h0000_1000_0000_1000, 64'h0, 5'd0},
    '{64'h8000_0000_0000_0001, 64'h8000_0000_0000_0001, 5'd0},
    '{64'h00F0_0000_0000_0F00, 64'h0, 5'h1F},
    '{64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0055, 5'd3}
  };

  function automatic int prio_of(int n);
    return (n * 5 + 3) % 16;
  endfunction

  // descending scan, strict compare: equal priority keeps the higher number
  function automatic logic [31:0] exp_norm(logic [63:0] p, logic [63:0] ty, int msk);
    int best = -1;
    int bp = 0;
    for (int i = 63; i >= 0; i--)
      if (p[i] && !ty[i] && prio_of(i) > msk && (best < 0 || prio_of(i) > bp)) begin
        best = i;
        bp = prio_of(i);
      end
    return (best < 0) ? 32'hFFFF0000 : {16'(best), 16'(bp)};
  endfunction

  function automatic logic [31:0] exp_fast(logic [63:0] p, logic [63:0] ty);
    for (int i = 63; i >= 0; i--)
      if (p[i] && ty[i]) return {16'(i), 16'h0};
    return 32'hFFFF0000;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr32(input logic [6:0] boff, input logic [31:0] v);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = boff[6:2]; wdata = v;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic rd32(input logic [6:0] boff, output logic [31:0] v);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = boff[6:2];
    @(negedge clk);
    v = rdata;
    sel = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd32(7'h04, d); check("R1 threshold", d, 32'h1F);
    rd32(7'h00, d); check("R1 control", d, 32'h0);
    rd32(7'h10, d); check("R1 enable high", d, 32'h0);
    rd32(7'h14, d); check("R1 enable low", d, 32'h0);
    rd32(7'h1C, d); check("R1 select low", d, 32'h0);
    rd32(7'h20, d); check("R1 priority word 7", d, 32'h0);
    rd32(7'h40, d); check("R1 ordinary vector", d, 32'hFFFF0000);
    rd32(7'h44, d); check("R1 fast vector", d, 32'hFFFF0000);
    check("R1 outputs", {30'h0, irq_n, irq_f}, 32'h0);

    // R2 numbered enable and disable
    wr32(7'h08, 32'd40); rd32(7'h10, d); check("R2 set 40", d, 32'h100);
    wr32(7'h08, 32'd3);  rd32(7'h14, d); check("R2 set 3", d, 32'h8);
    wr32(7'h08, 32'd64); rd32(7'h10, d); check("R2 set 64 ignored", d, 32'h100);
    wr32(7'h0C, 32'd40); rd32(7'h10, d); check("R2 clear 40", d, 32'h0);
    wr32(7'h0C, 32'h103); rd32(7'h14, d); check("R2 clear 259 ignored", d, 32'h8);

    // R3 pending views with only source 3 enabled
    wr32(7'h54, 32'h8);
    rd32(7'h5C, d); check("R3 force pends", d, 32'h8);
    rd32(7'h4C, d); check("R3 raw without input", d, 32'h0);
    wr32(7'h54, 32'h0);
    @(negedge clk); src = 64'h18;
    rd32(7'h4C, d); check("R3 raw inputs", d, 32'h18);
    rd32(7'h5C, d); check("R3 disabled source masked", d, 32'h8);
    wr32(7'h1C, 32'h8);
    rd32(7'h64, d); check("R3 fast pending", d, 32'h8);
    rd32(7'h5C, d); check("R3 ordinary pending empty", d, 32'h0);
    wr32(7'h1C, 32'h0);

    // R4 priority field placement at both ends
    wr32(7'h14, 32'hFFFF_FFFF); wr32(7'h10, 32'hFFFF_FFFF);
    wr32(7'h04, 32'h0);
    wr32(7'h3C, 32'h0000_00A0);
    @(negedge clk); src = 64'h2;
    rd32(7'h40, d); check("R4 source 1 in word 0", d, {16'd1, 16'hA});
    wr32(7'h20, 32'h7000_0000);
    @(negedge clk); src = 64'h8000_0000_0000_0000;
    rd32(7'h40, d); check("R4 source 63 in word 7", d, {16'd63, 16'h7});
    rd32(7'h3C, d); check("R4 word 0 readback", d, 32'h0000_00A0);

    // R9 readback and word split
    wr32(7'h18, 32'hA5A5_0000); rd32(7'h18, d); check("R9 select high", d, 32'hA5A5_0000);
    wr32(7'h18, 32'h0);
    wr32(7'h50, 32'h0000_0C00); rd32(7'h50, d); check("R9 force high", d, 32'h0000_0C00);
    rd32(7'h58, d); check("R9 force reaches high pending", d, 32'h8000_0C00);
    wr32(7'h50, 32'h0);
    wr32(7'h00, 32'h1234); rd32(7'h00, d); check("R9 control", d, 32'h1234);

    // table: programmed priorities, all enables on
    for (int x = 0; x < 8; x++) begin
      v = '0;
      for (int k = 0; k < 8; k++) v[4*k +: 4] = 4'(prio_of(8*x + k));
      wr32(7'(32 + 4*(7 - x)), v);
    end
    for (int e = 0; e < NV; e++) begin
      wr32(7'h18, TBL[e].t[63:32]);
      wr32(7'h1C, TBL[e].t[31:0]);
      wr32(7'h04, 32'(TBL[e].m));
      @(negedge clk); src = TBL[e].s;
      rd32(7'h40, d); check($sformatf("R5 R6 vector %0d ordinary", e), d, exp_norm(TBL[e].s, TBL[e].t, int'(TBL[e].m)));
      rd32(7'h44, d); check($sformatf("R7 vector %0d fast", e), d, exp_fast(TBL[e].s, TBL[e].t));
      check($sformatf("R6 vector %0d ordinary output", e), 32'(irq_n),
            32'(exp_norm(TBL[e].s, TBL[e].t, int'(TBL[e].m)) != 32'hFFFF0000));
      check($sformatf("R7 vector %0d fast output", e), 32'(irq_f),
            32'(exp_fast(TBL[e].s, TBL[e].t) != 32'hFFFF0000));
    end

    // R8 output timing: source 12 has priority 15
    wr32(7'h18, 32'h0); wr32(7'h1C, 32'h0); wr32(7'h04, 32'h0);
    @(negedge clk); src = '0;
    @(negedge clk); src = 64'h1000;
    #1 check("R8 no rise before edge", 32'(irq_n), 32'h0);
    @(negedge clk); check("R8 rise after one edge", 32'(irq_n), 32'h1);
    src = '0;
    #1 check("R8 held until edge", 32'(irq_n), 32'h1);
    @(negedge clk); check("R8 fall after one edge", 32'(irq_n), 32'h0);

    finish_run();
  end
endmodule